// File: doc/BRIEF.md
# Single-Entry Line Write Buffer

This block sits between a cache controller and a main memory that has independent read and write ports. The store path hands it a whole cache line together with its block address. The block keeps that pair in a one-deep holding register and writes it to memory on its own, using a start/done handshake with the memory's write port. While that write is running, the processor side keeps working. Only a further store has to wait, and it waits through ordinary valid/ready back-pressure.

Read misses also pass through the block as a lookup. A read hit never touches it. A miss whose block address equals the held address, while the holding register contains valid data, is answered with the held line. The cache fill then skips the memory read and its long latency. Any other miss is answered "not forwarded", and the controller fetches the block from memory through the separate read port, even while a write is still draining. The held entry keeps its valid flag after its write has finished and loses it only on reset, so the block never forwards an empty entry.

Store channel rules: a line transfers on a rising edge where `st_valid` and `st_ready` are both high. `st_ready` is low from the edge that accepts a store until the cycle after memory reports completion. While `st_ready` is low, the source must hold its request stable. The lookup channel has no back-pressure. Every cycle with `rd_valid` high produces exactly one response one cycle later.

Top module: `line_write_buffer`

## Requirements
- R1: While and after reset, `st_ready`=1, `busy`=0, `mem_wr_start`=0 and `rd_rsp_valid`=0.
- R2: The edge that accepts a store (`st_valid`&&`st_ready`) sets `busy` and clears `st_ready`. In the following cycle, `mem_wr_start` is high for exactly one cycle, with `mem_wr_addr`/`mem_wr_line` equal to the accepted address and line.
- R3: While `busy` is high, `mem_wr_addr` and `mem_wr_line` do not change.
- R4: `busy` stays high until a `mem_wr_done` pulse arrives after the start cycle. With a 20-cycle memory, `busy` lasts at least 20 cycles. In the cycle after the done pulse, `busy`=0 and `st_ready`=1.
- R5: A store presented while `busy` is high is not accepted, and the held entry is unchanged. It is accepted once the pending write completes.
- R6: A lookup in cycle t gives `rd_rsp_valid`=1 in cycle t+1. `rd_rsp_fwd`=1 and `rd_rsp_line` = held line exactly when the entry is valid and its address equals `rd_addr`. Otherwise `rd_rsp_fwd`=0 and `rd_rsp_line`=0.
- R7: Forwarding works both while the entry is draining and after its write has completed.
- R8: After reset, no lookup is forwarded, whatever its address.
- R9: When a store is accepted in the same cycle as a lookup, the lookup sees the newly stored entry. It forwards the new line for the new address and does not forward for the address that was replaced.
- R10: Lookups are never stalled: a response arrives one cycle after each lookup, also while `busy` is high.
- R11: A `mem_wr_done` pulse is ignored when no write is outstanding and during the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store line offered |
| st_ready | output | 1 | Buffer can take a store this cycle |
| st_addr | input | ADDR_W | Block address of the store |
| st_line | input | LINE_W | Full line to write |
| rd_valid | input | 1 | Read-miss lookup this cycle |
| rd_addr | input | ADDR_W | Block address of the miss |
| rd_rsp_valid | output | 1 | Lookup response valid |
| rd_rsp_fwd | output | 1 | One-cycle pulse: line supplied from buffer |
| rd_rsp_line | output | LINE_W | Forwarded line, zero when not forwarded |
| busy | output | 1 | Memory write outstanding |
| mem_wr_start | output | 1 | One-cycle request to begin a memory write |
| mem_wr_addr | output | ADDR_W | Block address of the write |
| mem_wr_line | output | LINE_W | Line being written |
| mem_wr_done | input | 1 | Memory reports the write finished |

## Verification
The hardest situations to reach are those where two actions overlap in one cycle or in one drain window. Examples are a store that collides with a lookup to the same block, and a second store that waits while lookups to the held block keep getting forwarded. The bench drives both channels from the same falling edge so that such collisions occur on a chosen edge. It holds a second store through a whole 20-cycle drain while it interleaves lookups. It also injects stray done pulses, both while idle and exactly in the start cycle.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_ISSUE = 2'd1,
    DR_WAIT  = 2'd2
  } drain_state_e;
endpackage

// File: rtl/lwb_entry.sv
module lwb_entry #(
  parameter int ADDR_W = 8,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LINE_W-1:0] load_line,
  output logic              ent_valid,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [LINE_W-1:0] ent_line
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= 1'b0;
      ent_addr  <= '0;
      ent_line  <= '0;
    end else if (load) begin
      ent_valid <= 1'b1;
      ent_addr  <= load_addr;
      ent_line  <= load_line;
    end
  end

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |=> ent_valid);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ent_valid && ent_addr == $past(load_addr) && ent_line == $past(load_line)));
endmodule

// File: rtl/lwb_drain.sv
module lwb_drain
  import lwb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic mem_wr_done,
  output logic busy,
  output logic idle,
  output logic mem_wr_start
);
  drain_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DR_IDLE:  if (accept) state_d = DR_ISSUE;
      DR_ISSUE: state_d = DR_WAIT;
      DR_WAIT:  if (mem_wr_done) state_d = DR_IDLE;
      default:  state_d = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= DR_IDLE;
    else        state_q <= state_d;
  end

  assign idle         = (state_q == DR_IDLE);
  assign busy         = !idle;
  assign mem_wr_start = (state_q == DR_ISSUE);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_start |=> (!mem_wr_start && busy));

  // R11
  early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_start && mem_wr_done) |=> busy);

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !accept && mem_wr_done) |=> idle);
endmodule

// File: rtl/lwb_fwd.sv
module lwb_fwd #(
  parameter int ADDR_W = 8,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              st_take,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LINE_W-1:0] st_line,
  input  logic              ent_valid,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [LINE_W-1:0] ent_line,
  output logic              rsp_valid,
  output logic              rsp_fwd,
  output logic [LINE_W-1:0] rsp_line
);
  logic              view_valid;
  logic [ADDR_W-1:0] view_addr;
  logic [LINE_W-1:0] view_line;
  logic              match;

  // A store taken this cycle is ordered ahead of the lookup.
  always_comb begin
    if (st_take) begin
      view_valid = 1'b1;
      view_addr  = st_addr;
      view_line  = st_line;
    end else begin
      view_valid = ent_valid;
      view_addr  = ent_addr;
      view_line  = ent_line;
    end
    match = rd_valid && view_valid && (view_addr == rd_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fwd   <= 1'b0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      rsp_fwd   <= match;
      rsp_line  <= match ? view_line : '0;
    end
  end

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  // R6
  fwd_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fwd |-> rsp_valid);

  // R6
  miss_zero_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fwd |-> (rsp_line == '0));
endmodule

// File: rtl/line_write_buffer.sv
module line_write_buffer #(
  parameter int ADDR_W     = 8,
  parameter int WORD_W     = 8,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [LINE_W-1:0] st_line,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_rsp_valid,
  output logic              rd_rsp_fwd,
  output logic [LINE_W-1:0] rd_rsp_line,
  output logic              busy,
  output logic              mem_wr_start,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_line,
  input  logic              mem_wr_done
);
  logic              take;
  logic              idle;
  logic              ent_valid;
  logic [ADDR_W-1:0] ent_addr;
  logic [LINE_W-1:0] ent_line;

  assign st_ready = idle;
  assign take     = st_valid && idle;

  lwb_entry #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_entry (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .load_addr (st_addr),
    .load_line (st_line),
    .ent_valid (ent_valid),
    .ent_addr  (ent_addr),
    .ent_line  (ent_line)
  );

  lwb_drain u_drain (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (take),
    .mem_wr_done  (mem_wr_done),
    .busy         (busy),
    .idle         (idle),
    .mem_wr_start (mem_wr_start)
  );

  lwb_fwd #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .st_take   (take),
    .st_addr   (st_addr),
    .st_line   (st_line),
    .ent_valid (ent_valid),
    .ent_addr  (ent_addr),
    .ent_line  (ent_line),
    .rsp_valid (rd_rsp_valid),
    .rsp_fwd   (rd_rsp_fwd),
    .rsp_line  (rd_rsp_line)
  );

  assign mem_wr_addr = ent_addr;
  assign mem_wr_line = ent_line;

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> (mem_wr_start && busy && !st_ready));

  // R3
  drain_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_wr_start) |-> ($stable(mem_wr_addr) && $stable(mem_wr_line)));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> ($stable(mem_wr_addr) && $stable(mem_wr_line)));
endmodule

// File: tb/test_line_write_buffer.sv
`timescale 1ns/100ps
module test_line_write_buffer;
  localparam int AW = 8;
  localparam int LW = 32;
  localparam int MEM_LAT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, rd_valid = 1'b0, stray_done = 1'b0;
  logic [AW-1:0] st_addr = '0, rd_addr = '0;
  logic [LW-1:0] st_line = '0;
  logic st_ready, rd_rsp_valid, rd_rsp_fwd, busy, mem_wr_start, mem_wr_done, model_done;
  logic [LW-1:0] rd_rsp_line, mem_wr_line;
  logic [AW-1:0] mem_wr_addr;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  line_write_buffer #(.ADDR_W(AW), .WORD_W(8), .LINE_WORDS(4)) i_line_write_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_line(st_line),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_fwd(rd_rsp_fwd), .rd_rsp_line(rd_rsp_line),
    .busy(busy), .mem_wr_start(mem_wr_start), .mem_wr_addr(mem_wr_addr),
    .mem_wr_line(mem_wr_line), .mem_wr_done(mem_wr_done)
  );

  // Memory write port model with fixed latency.
  logic [LW-1:0] mem [256];
  int mcnt;
  assign mem_wr_done = model_done | stray_done;
  always_ff @(posedge clk) begin
    model_done <= 1'b0;
    if (!rst_n) begin
      mcnt <= 0;
    end else if (mem_wr_start) begin
      mcnt <= MEM_LAT;
    end else if (mcnt != 0) begin
      mcnt <= mcnt - 1;
      if (mcnt == 1) begin
        mem[mem_wr_addr] <= mem_wr_line;
        model_done <= 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Returns at the falling edge after the accepting rising edge.
  task automatic do_store(input logic [AW-1:0] a, input logic [LW-1:0] d);
    st_valid = 1'b1; st_addr = a; st_line = d;
    while (!st_ready) step();
    step();
    st_valid = 1'b0;
  endtask

  task automatic do_miss(input logic [AW-1:0] a, input bit exp_fwd,
                         input logic [LW-1:0] exp_line, input string tag);
    rd_valid = 1'b1; rd_addr = a;
    step();
    rd_valid = 1'b0;
    check(rd_rsp_valid == 1'b1, tag, rd_rsp_valid, 1);
    check(rd_rsp_fwd == exp_fwd, tag, rd_rsp_fwd, exp_fwd);
    check(rd_rsp_line == (exp_fwd ? exp_line : '0), tag, rd_rsp_line, exp_fwd ? exp_line : '0);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; step(); end
  endtask

  typedef struct packed {
    logic          is_store;
    logic [AW-1:0] addr;
    logic [LW-1:0] line;
    logic          fwd;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b0, 8'h05, 32'h0000_0000, 1'b0},
    '{1'b1, 8'h05, 32'hA1A2_A3A4, 1'b0},
    '{1'b0, 8'h05, 32'hA1A2_A3A4, 1'b1},
    '{1'b0, 8'h06, 32'h0000_0000, 1'b0},
    '{1'b1, 8'h06, 32'hB5B6_B7B8, 1'b0},
    '{1'b0, 8'h05, 32'h0000_0000, 1'b0},
    '{1'b0, 8'h06, 32'hB5B6_B7B8, 1'b1}
  };

  initial begin
    int nb;
    repeat (3) step();
    // R1 during reset
    check(st_ready == 1 && busy == 0 && mem_wr_start == 0 && rd_rsp_valid == 0,
          "R1 in reset", {st_ready, busy, mem_wr_start, rd_rsp_valid}, 4'b1000);
    rst_n = 1'b1;
    step();
    check(st_ready == 1 && busy == 0 && mem_wr_start == 0 && rd_rsp_valid == 0,
          "R1 after reset", {st_ready, busy, mem_wr_start, rd_rsp_valid}, 4'b1000);

    for (int i = 0; i < 7; i++) begin
      if (VEC[i].is_store) begin
        do_store(VEC[i].addr, VEC[i].line);
        check(mem_wr_start && busy && !st_ready, "R2 start pulse",
              {mem_wr_start, busy, st_ready}, 3'b110);
        check(mem_wr_addr == VEC[i].addr && mem_wr_line == VEC[i].line, "R2 write data",
              {mem_wr_addr, mem_wr_line}, {VEC[i].addr, VEC[i].line});
        step();
        check(!mem_wr_start && busy, "R2 single start", {mem_wr_start, busy}, 2'b01);
        wait_idle(nb);
        check(nb >= MEM_LAT - 1, "R4 busy length", nb, MEM_LAT - 1);
        check(st_ready == 1'b1, "R4 ready after done", st_ready, 1);
        check(mem[VEC[i].addr] == VEC[i].line, "R4 memory updated",
              mem[VEC[i].addr], VEC[i].line);
      end else begin
        do_miss(VEC[i].addr, VEC[i].fwd, VEC[i].line, "R6 R7 vector lookup");
      end
    end

    // R5 / R7 / R10 / R3: second store held during drain, lookups keep flowing.
    do_store(8'h20, 32'h1111_2222);
    st_valid = 1'b1; st_addr = 8'h21; st_line = 32'h3333_4444;
    step();
    check(st_ready == 1'b0, "R5 second store stalled", st_ready, 0);
    do_miss(8'h20, 1'b1, 32'h1111_2222, "R5 R7 forward while draining");
    do_miss(8'h30, 1'b0, '0, "R10 lookup not stalled by busy");
    check(mem_wr_addr == 8'h20 && mem_wr_line == 32'h1111_2222, "R3 held during drain",
          {mem_wr_addr, mem_wr_line}, {8'h20, 32'h1111_2222});
    while (!st_ready) step();
    step();
    st_valid = 1'b0;
    check(mem_wr_start && mem_wr_addr == 8'h21, "R5 accepted after drain",
          {mem_wr_start, mem_wr_addr}, {1'b1, 8'h21});
    check(mem[8'h20] == 32'h1111_2222, "R5 first write done", mem[8'h20], 32'h1111_2222);
    wait_idle(nb);
    check(mem[8'h21] == 32'h3333_4444, "R5 second write done", mem[8'h21], 32'h3333_4444);
    do_miss(8'h21, 1'b1, 32'h3333_4444, "R7 forward after drain");

    // R11: stray done pulses.
    stray_done = 1'b1; step(); stray_done = 1'b0;
    check(!busy && st_ready, "R11 idle done ignored", {busy, st_ready}, 2'b01);
    do_store(8'h50, 32'h5555_6666);
    stray_done = 1'b1; step(); stray_done = 1'b0;
    check(busy == 1'b1, "R11 done in start cycle ignored", busy, 1);
    wait_idle(nb);
    check(mem[8'h50] == 32'h5555_6666, "R11 write still completes", mem[8'h50], 32'h5555_6666);

    // R9: store and lookup in the same cycle.
    st_valid = 1'b1; st_addr = 8'h40; st_line = 32'hC0C1_C2C3;
    rd_valid = 1'b1; rd_addr = 8'h40;
    step();
    st_valid = 1'b0; rd_valid = 1'b0;
    check(rd_rsp_fwd && rd_rsp_line == 32'hC0C1_C2C3, "R9 same-cycle forward",
          {rd_rsp_fwd, rd_rsp_line}, {1'b1, 32'hC0C1_C2C3});
    wait_idle(nb);
    st_valid = 1'b1; st_addr = 8'h41; st_line = 32'hD0D1_D2D3;
    rd_valid = 1'b1; rd_addr = 8'h40;
    step();
    st_valid = 1'b0; rd_valid = 1'b0;
    check(rd_rsp_valid && !rd_rsp_fwd, "R9 replaced address not forwarded",
          {rd_rsp_valid, rd_rsp_fwd}, 2'b10);
    wait_idle(nb);

    // R8: reset clears the entry.
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
    check(st_ready && !busy && !rd_rsp_valid, "R1 after second reset",
          {st_ready, busy, rd_rsp_valid}, 3'b100);
    do_miss(8'h41, 1'b0, '0, "R8 no forward after reset");
    do_miss(8'h00, 1'b0, '0, "R8 no forward for zero address");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule